// File: doc/BRIEF.md
# Load/Store Unit with Character Output

This block sits between a processor's load/store datapath and two targets: a byte-addressed RAM reached over a 32-bit word port with byte enables, and a write-only character output. A request carries a base value, a signed 12-bit displacement, an access size, a signedness flag and, for stores, the data. The block forms the effective address and decodes which target it hits. It then moves the bytes in little-endian order and returns a response.

Accesses that sit on their natural boundary finish in one RAM transaction. The byte enables and the write data are placed on the lanes that the low address bits select. Halfword and word accesses that are not aligned do not fault. They become a series of single-byte transactions in ascending address order, and the load result is built up one byte at a time. A store to the character address sends the low byte of the store data out through a valid/ready port. The block holds that byte until the port accepts it.

Requests enter through a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both signals are high. `busy` stays high from that edge until the response has been handed over. The response is a valid/ready pair. While `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold their values. In the same way, `chr_valid` and `chr_data` hold while `chr_ready` is low.

Top module: `ldst_unit`

## Requirements
- R1: Byte order is little-endian. Bytes 0x01, 0x02, 0x03, 0x04 stored at four ascending addresses read back as the word 0x04030201.
- R2: Signed loads copy the top bit of the loaded byte or halfword into every upper bit. `req_size` 0 is byte, 1 is halfword, and 2 or 3 is word. `req_unsigned` is 0 for signed loads. A byte 0x9C loads as 0xFFFFFF9C.
- R3: Loads with `req_unsigned` = 1 fill the upper bits with zeros. A byte 0x9C loads as 0x0000009C.
- R4: The effective address is `req_base` plus `req_offset` sign-extended from 12 bits. This holds for both loads and stores, and negative displacements count down.
- R5: Only addresses 0x40000000 to 0x400FFFFF reach the RAM port. `mem_addr` carries effective address bits [19:2].
- R6: An aligned access makes exactly one RAM transaction. The byte enables start at lane addr[1:0], and the store data is shifted onto those lanes.
- R7: A misaligned halfword or word access makes one single-byte RAM transaction per byte, each with exactly one byte enable. Its load result or stored bytes match those of an aligned access to the same bytes.
- R8: A store to 0x10000000 raises `chr_valid` with the low 8 bits of the store data on `chr_data`. Both hold until `chr_ready` is seen high, and each such store gives exactly one character.
- R9: Loads from 0x10000000 or from an unmapped address return 0 and make no RAM transaction. Stores to an unmapped address make no RAM transaction and produce no character.
- R10: `req_ready` is high only when the block is idle. `busy` is high from acceptance until the response is taken. `rsp_valid` and `rsp_rdata` hold while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend a load when high |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Signed displacement |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Load result (0 for stores) |
| busy | output | 1 | Stall to the requester |
| mem_en | output | 1 | RAM transaction this cycle |
| mem_we | output | 1 | RAM write |
| mem_addr | output | 18 | RAM word index inside the window |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read word, valid the cycle after a read |
| chr_valid | output | 1 | Character offered |
| chr_ready | input | 1 | Character sink accepts |
| chr_data | output | 8 | Character byte |

## Verification
The assertions assume a requester that holds `rsp_ready` and `chr_ready` as plain levels. They also assume a RAM that returns read data exactly one cycle after `mem_en` with `mem_we` low. The bench's memory model keeps to that fixed one-cycle latency. Its driver offers a request only when the unit is idle and drops `req_valid` right after acceptance. Back-pressure is applied only by holding a ready input low for a few cycles, which the hold properties expect.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int XLEN = 32;
  localparam int NLANE = XLEN / 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {RG_NONE, RG_RAM, RG_CHR} region_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_CHAR, ST_RESP
  } state_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ldst_addr_decode.sv
module ldst_addr_decode
  import ldst_pkg::*;
#(
  parameter logic [31:0] RAM_BASE = 32'h4000_0000,
  parameter int          RAM_AW   = 20,
  parameter logic [31:0] CHR_ADDR = 32'h1000_0000,
  parameter int          OFF_W    = 12
) (
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  output logic [XLEN-1:0]  eff_addr,
  output region_e          region,
  output logic             misaligned,
  output logic [2:0]       nbytes
);
  localparam int TAG_W = XLEN - RAM_AW;

  logic [XLEN-1:0] off_ext;

  assign off_ext  = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
  assign eff_addr = base + off_ext;
  assign nbytes   = size_bytes(size);

  always_comb begin
    if (eff_addr[XLEN-1 -: TAG_W] == RAM_BASE[XLEN-1 -: TAG_W])
      region = RG_RAM;
    else if (eff_addr == CHR_ADDR)
      region = RG_CHR;
    else
      region = RG_NONE;
  end

  always_comb begin
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = eff_addr[0];
      default: misaligned = |eff_addr[1:0];
    endcase
  end
endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
  import ldst_pkg::*;
(
  input  logic [1:0]      lane,
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] data,
  output logic [NLANE-1:0] be,
  output logic [XLEN-1:0] lane_data
);
  logic [NLANE-1:0] base_mask;

  always_comb begin
    case (size)
      SZ_BYTE: base_mask = 4'b0001;
      SZ_HALF: base_mask = 4'b0011;
      default: base_mask = 4'b1111;
    endcase
  end

  assign be        = base_mask << lane;
  assign lane_data = data << {lane, 3'b000};
endmodule

// File: rtl/ldst_load_extend.sv
module ldst_load_extend
  import ldst_pkg::*;
(
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      size,
  input  logic            zero_ext,
  output logic [XLEN-1:0] result
);
  logic b_fill, h_fill;

  assign b_fill = ~zero_ext & raw[7];
  assign h_fill = ~zero_ext & raw[15];

  always_comb begin
    case (size)
      SZ_BYTE: result = {{(XLEN-8){b_fill}}, raw[7:0]};
      SZ_HALF: result = {{(XLEN-16){h_fill}}, raw[15:0]};
      default: result = raw;
    endcase
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter logic [31:0] RAM_BASE = 32'h4000_0000,
  parameter int          RAM_AW   = 20,
  parameter logic [31:0] CHR_ADDR = 32'h1000_0000,
  parameter int          OFF_W    = 12,
  localparam int         MA_W     = RAM_AW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [31:0]       req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              busy,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              chr_valid,
  input  logic              chr_ready,
  output logic [7:0]        chr_data
);
  // request decode
  logic [XLEN-1:0] dec_addr;
  region_e         dec_region;
  logic            dec_mis;
  logic [2:0]      dec_nbytes;

  ldst_addr_decode #(
    .RAM_BASE(RAM_BASE), .RAM_AW(RAM_AW), .CHR_ADDR(CHR_ADDR), .OFF_W(OFF_W)
  ) u_dec (
    .base(req_base), .offset(req_offset), .size(req_size),
    .eff_addr(dec_addr), .region(dec_region),
    .misaligned(dec_mis), .nbytes(dec_nbytes)
  );

  // captured request
  state_e          state_q;
  logic            we_q, uns_q, split_q;
  logic [1:0]      size_q;
  logic [XLEN-1:0] addr_q, wdata_q, asm_q;
  region_e         region_q;
  logic [2:0]      beat_q, nbeat_q;

  logic            accept, last_beat;
  logic [XLEN-1:0] beat_addr;
  logic [1:0]      lane;
  logic [1:0]      beat_size;
  logic [XLEN-1:0] beat_src;
  logic [XLEN-1:0] rd_shift;
  logic [XLEN-1:0] asm_n;

  assign accept    = req_valid && req_ready;
  assign last_beat = (beat_q == nbeat_q - 3'd1);
  assign beat_addr = split_q ? addr_q + {{(XLEN-3){1'b0}}, beat_q} : addr_q;
  assign lane      = beat_addr[1:0];
  assign beat_size = split_q ? SZ_BYTE : size_q;
  assign beat_src  = wdata_q >> {beat_q[1:0], 3'b000};

  // store lane steering
  ldst_store_lanes u_lanes (
    .lane(lane), .size(beat_size), .data(beat_src),
    .be(mem_be), .lane_data(mem_wdata)
  );

  // load capture: per-lane merge into the assembly register
  assign rd_shift = mem_rdata >> {lane, 3'b000};

  for (genvar b = 0; b < NLANE; b++) begin : g_asm
    logic hit;
    assign hit = split_q ? (beat_q[1:0] == b[1:0]) : 1'b1;
    if (b == 0) begin : g_first
      assign asm_n[7:0] = hit ? rd_shift[7:0] : asm_q[7:0];
    end else begin : g_rest
      assign asm_n[8*b +: 8] = !hit ? asm_q[8*b +: 8]
                             : (split_q ? rd_shift[7:0] : rd_shift[8*b +: 8]);
    end
  end

  // load extension
  logic [XLEN-1:0] ld_result;

  ldst_load_extend u_ext (
    .raw(asm_q), .size(size_q), .zero_ext(uns_q), .result(ld_result)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      we_q     <= 1'b0;
      uns_q    <= 1'b0;
      split_q  <= 1'b0;
      size_q   <= SZ_BYTE;
      addr_q   <= '0;
      wdata_q  <= '0;
      asm_q    <= '0;
      region_q <= RG_NONE;
      beat_q   <= '0;
      nbeat_q  <= 3'd1;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          we_q     <= req_we;
          uns_q    <= req_unsigned;
          size_q   <= req_size;
          addr_q   <= dec_addr;
          wdata_q  <= req_wdata;
          region_q <= dec_region;
          split_q  <= dec_mis;
          nbeat_q  <= dec_mis ? dec_nbytes : 3'd1;
          beat_q   <= '0;
          asm_q    <= '0;
          if (dec_region == RG_RAM)              state_q <= ST_ISSUE;
          else if (dec_region == RG_CHR && req_we) state_q <= ST_CHAR;
          else                                   state_q <= ST_RESP;
        end
        ST_ISSUE: begin
          if (!we_q) state_q <= ST_WAIT;
          else if (last_beat) state_q <= ST_RESP;
          else beat_q <= beat_q + 3'd1;
        end
        ST_WAIT: begin
          asm_q <= asm_n;
          if (last_beat) state_q <= ST_RESP;
          else begin
            beat_q  <= beat_q + 3'd1;
            state_q <= ST_ISSUE;
          end
        end
        ST_CHAR: if (chr_ready) state_q <= ST_RESP;
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign mem_en    = (state_q == ST_ISSUE);
  assign mem_we    = mem_en && we_q;
  assign mem_addr  = beat_addr[RAM_AW-1:2];
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = we_q ? '0 : ld_result;
  assign chr_valid = (state_q == ST_CHAR);
  assign chr_data  = wdata_q[7:0];

  // properties
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  assert_chr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid && !chr_ready |=> chr_valid && $stable(chr_data));
  assert_ram_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> region_q == RG_RAM && !req_ready);
  assert_split_single_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && split_q |-> $countones(mem_be) == 1);
  assert_no_char_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |-> we_q && region_q == RG_CHR);
endmodule

// File: tb/tb_ldst_unit.sv
module tb_ldst_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_we = 0, req_unsigned = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_base = 0, req_wdata = 0;
  logic [11:0] req_offset = 0;
  logic        rsp_ready = 1, chr_ready = 1;
  logic        req_ready, rsp_valid, busy, mem_en, mem_we, chr_valid;
  logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [17:0] mem_addr;
  logic [3:0]  mem_be;
  logic [7:0]  chr_data;

  ldst_unit dut (.*);

  // RAM model: 64 words, 1-cycle read latency
  logic [7:0] bmem [256];
  logic [7:0] refm [256];
  logic [31:0] rd_q;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (mem_en) begin
      for (int k = 0; k < 4; k++) begin
        if (mem_we && mem_be[k]) bmem[{mem_addr[5:0], 2'(k)}] <= mem_wdata[8*k +: 8];
      end
      rd_q <= {bmem[{mem_addr[5:0], 2'd3}], bmem[{mem_addr[5:0], 2'd2}],
               bmem[{mem_addr[5:0], 2'd1}], bmem[{mem_addr[5:0], 2'd0}]};
    end
  end

  logic [7:0] chr_log [16];
  int chr_cnt = 0;
  always @(posedge clk) if (chr_valid && chr_ready && chr_cnt < 16) begin
    chr_log[chr_cnt] <= chr_data;
    chr_cnt <= chr_cnt + 1;
  end

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] o_data, o_addr;
  int o_beats;

  task automatic do_op(input logic we, input logic [1:0] sz, input logic uns,
                       input logic [31:0] base, input logic [11:0] off,
                       input logic [31:0] wd);
    int guard = 0;
    @(negedge clk);
    req_valid = 1; req_we = we; req_size = sz; req_unsigned = uns;
    req_base = base; req_offset = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    o_beats = 0; o_addr = 0;
    while (!rsp_valid && guard < 200) begin
      if (mem_en) begin o_beats++; o_addr = {14'd0, mem_addr}; end
      @(negedge clk);
      guard++;
    end
    o_data = rsp_rdata;
    if (rsp_ready) @(negedge clk);
  endtask

  function automatic int nb(input logic [1:0] sz);
    return sz == 2'd0 ? 1 : (sz == 2'd1 ? 2 : 4);
  endfunction

  function automatic logic [31:0] exp_load(input logic [7:0] a, input logic [1:0] sz,
                                           input logic uns);
    logic [31:0] raw = 0;
    for (int k = 0; k < nb(sz); k++) raw[8*k +: 8] = refm[8'(a + k)];
    if (sz == 2'd0) return uns ? raw & 32'hFF : {{24{raw[7]}}, raw[7:0]};
    if (sz == 2'd1) return uns ? raw & 32'hFFFF : {{16{raw[15]}}, raw[15:0]};
    return raw;
  endfunction

  function automatic int exp_beats(input logic [7:0] a, input logic [1:0] sz);
    if (sz == 2'd0) return 1;
    if (sz == 2'd1) return a[0] ? 2 : 1;
    return (a[1:0] != 0) ? 4 : 1;
  endfunction

  // {we, size, unsigned, offset byte, data}
  localparam logic [43:0] VEC [16] = '{
    {1'b1, 2'd2, 1'b0, 8'h80, 32'hA1B2C3D4},
    {1'b0, 2'd2, 1'b1, 8'h80, 32'h0},
    {1'b0, 2'd1, 1'b0, 8'h81, 32'h0},
    {1'b0, 2'd1, 1'b1, 8'h82, 32'h0},
    {1'b1, 2'd1, 1'b0, 8'h85, 32'h00001234},
    {1'b0, 2'd2, 1'b0, 8'h84, 32'h0},
    {1'b1, 2'd2, 1'b0, 8'h87, 32'hCAFEF00D},
    {1'b0, 2'd2, 1'b0, 8'h87, 32'h0},
    {1'b0, 2'd2, 1'b0, 8'h86, 32'h0},
    {1'b1, 2'd0, 1'b0, 8'h8B, 32'h00000080},
    {1'b0, 2'd0, 1'b0, 8'h8B, 32'h0},
    {1'b0, 2'd0, 1'b1, 8'h8B, 32'h0},
    {1'b1, 2'd1, 1'b0, 8'h8E, 32'h00007F01},
    {1'b0, 2'd1, 1'b0, 8'h8E, 32'h0},
    {1'b0, 2'd2, 1'b0, 8'h8D, 32'h0},
    {1'b0, 2'd1, 1'b1, 8'h8F, 32'h0}
  };

  initial begin
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'(i * 7 + 3);
      refm[i] = 8'(i * 7 + 3);
    end
    rd_q = 0;
    repeat (3) @(negedge clk);
    // reset state
    check("reset R10 req_ready", {31'd0, req_ready}, 32'd1);
    check("reset R10 busy/rsp/mem/chr", {28'd0, busy, rsp_valid, mem_en, chr_valid}, 32'd0);
    rst_n = 1;

    // table walk (R4 with positive and negative displacements, R6, R7)
    for (int i = 0; i < 16; i++) begin
      logic we; logic [1:0] sz; logic uns; logic [7:0] a; logic [31:0] d;
      logic [31:0] base; logic [11:0] off;
      {we, sz, uns, a, d} = VEC[i];
      if (i % 2 == 0) begin base = 32'h4000_0100; off = 12'(int'(a) - 256); end
      else begin base = 32'h4000_0000; off = {4'd0, a}; end
      do_op(we, sz, uns, base, off, d);
      check($sformatf("R6 R7 beats vec%0d", i), o_beats, exp_beats(a, sz));
      if (we) begin
        for (int k = 0; k < nb(sz); k++) refm[8'(a + k)] = d[8*k +: 8];
        check($sformatf("R4 store rsp vec%0d", i), o_data, 32'd0);
      end else begin
        check($sformatf("R2 R3 R7 load vec%0d", i), o_data, exp_load(a, sz, uns));
      end
    end

    // sweep every size, signedness and lane offset
    for (int sz = 0; sz < 3; sz++)
      for (int u = 0; u < 2; u++)
        for (int o = 0; o < 4; o++) begin
          logic [7:0] a = 8'(8'h20 + o);
          do_op(1'b0, 2'(sz), 1'(u), 32'h4000_0000, {4'd0, a}, 32'h0);
          check($sformatf("R2 R3 R7 sweep sz%0d u%0d o%0d", sz, u, o), o_data,
                exp_load(a, 2'(sz), 1'(u)));
          check($sformatf("R6 R7 sweep beats sz%0d o%0d", sz, o), o_beats, exp_beats(a, 2'(sz)));
        end

    // R1 little-endian assembly
    for (int k = 0; k < 4; k++) begin
      do_op(1'b1, 2'd0, 1'b0, 32'h4000_0040, 12'(k), 32'(k + 1));
      refm[8'h40 + k] = 8'(k + 1);
    end
    do_op(1'b0, 2'd2, 1'b0, 32'h4000_0040, 12'd0, 0);
    check("R1 word from bytes", o_data, 32'h04030201);

    // R2 / R3 with byte 0x9C
    do_op(1'b1, 2'd0, 1'b0, 32'h4000_0050, 12'd0, 32'h0000009C);
    refm[8'h50] = 8'h9C;
    do_op(1'b0, 2'd0, 1'b0, 32'h4000_0050, 12'd0, 0);
    check("R2 signed byte 9C", o_data, 32'hFFFFFF9C);
    do_op(1'b0, 2'd0, 1'b1, 32'h4000_0050, 12'd0, 0);
    check("R3 unsigned byte 9C", o_data, 32'h0000009C);

    // R4 most negative displacement
    do_op(1'b0, 2'd2, 1'b0, 32'h4000_0880, 12'h800, 0);
    check("R4 offset -2048", o_data, exp_load(8'h80, 2'd2, 1'b0));

    // R5 window edges
    do_op(1'b0, 2'd2, 1'b0, 32'h400F_FFFC, 12'd0, 0);
    check("R5 top word index", o_addr, 32'h0003FFFF);
    check("R5 top word one beat", o_beats, 1);
    do_op(1'b0, 2'd2, 1'b0, 32'h4010_0000, 12'd0, 0);
    check("R5 above window beats", o_beats, 0);
    check("R5 above window data", o_data, 0);

    // R9 unmapped / device loads, unmapped store
    do_op(1'b0, 2'd2, 1'b0, 32'h1000_0000, 12'd0, 0);
    check("R9 device load data", o_data, 0);
    check("R9 device load beats", o_beats, 0);
    do_op(1'b1, 2'd2, 1'b0, 32'h2000_0000, 12'd0, 32'h41);
    check("R9 unmapped store beats", o_beats, 0);
    check("R9 unmapped store chars", chr_cnt, 0);

    // R8 character stream with back-pressure on the first character
    chr_ready = 0;
    fork
      do_op(1'b1, 2'd2, 1'b0, 32'h1000_0000, 12'd0, 32'hABCD_0048);
      begin
        repeat (5) @(negedge clk);
        check("R8 char held valid", {31'd0, chr_valid}, 32'd1);
        check("R8 char held data", {24'd0, chr_data}, 32'h48);
        chr_ready = 1;
      end
    join
    do_op(1'b1, 2'd2, 1'b0, 32'h0FFF_FFFF, 12'd1, 32'h0000_0069);
    do_op(1'b1, 2'd2, 1'b0, 32'h1000_0010, 12'hFF0, 32'h0000_000A);
    check("R8 char count", chr_cnt, 3);
    check("R8 char stream", {8'd0, chr_log[0], chr_log[1], chr_log[2]}, 32'h0048690A);
    check("R8 no RAM beats", o_beats, 0);

    // R10 response back-pressure
    rsp_ready = 0;
    do_op(1'b0, 2'd2, 1'b0, 32'h4000_0040, 12'd0, 0);
    repeat (3) @(negedge clk);
    check("R10 rsp held", {29'd0, rsp_valid, busy, req_ready}, 32'b110);
    check("R10 rsp data held", rsp_rdata, 32'h04030201);
    rsp_ready = 1;
    @(negedge clk);
    check("R10 released", {29'd0, rsp_valid, busy, req_ready}, 32'b001);

    // final memory image vs reference (R6 R7 store lanes)
    begin
      int mism = 0;
      for (int i = 0; i < 256; i++) if (bmem[i] !== refm[i]) mism++;
      check("R6 R7 memory image", mism, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule